// File: doc/BRIEF.md
# Reservation-Set Wait Stall Controller

This block sits beside a hart's execute stage and handles the two wait-on-reservation instructions. One variant has no timeout. The other has a short timeout. When a matching instruction issues and the reservation set is still valid with nothing pending, the block holds the hart in a stall and requests low power. The wait ends and the instruction retires in any of these cases:

- the reservation is lost;
- any interrupt line becomes pending, whether or not it is enabled;
- an implementation wake is signalled;
- for the short-timeout variant only, its own cycle budget runs out.

The no-timeout variant can also turn a long wait into an exception. Outside M mode with TW set, it raises illegal instruction. In a virtualized mode with VTW set and TW clear, it raises virtual instruction. Both cases use a separate trap budget. Reservation tracking, interrupt masking and trap delivery are outside the block and appear only as ports.

Privilege is encoded as 2'b00 user, 2'b01 supervisor and 2'b11 machine. The `virt` input marks the guest forms of user and supervisor.

Top module: `rsv_wait_ctrl`

## Requirements
- R1: An instruction is recognised only when insn[6:0]=0x73, insn[11:7]=0, insn[14:12]=0 and insn[19:15]=0, with insn[31:20] equal to 0x00D (no-timeout) or 0x01D (short-timeout). Any other word presented with `issue_valid` produces no `done` and no stall.
- R2: If `rsv_valid` is low or any `irq_pending` bit is high in the issue cycle, `done` pulses in that cycle and `stall_active` stays low.
- R3: While stalled, a low `rsv_valid` makes `done` high in that cycle, and `stall_active` is low the cycle after.
- R4: While stalled, any set bit of `irq_pending` ends the stall with `done` in that cycle. There is no enable input.
- R5: A short-timeout stall with no other wake pulses `done` in its STO_CYC-th stall cycle and never raises an exception.
- R6: A no-timeout stall at machine privilege never raises an exception, however long it lasts.
- R7: A no-timeout stall outside machine mode with `tw` set and no wake raises `ill_exc`, not `done`, in its TRAP_CYC-th stall cycle, and the stall ends.
- R8: With `virt` set, privilege not machine, `vtw` set and `tw` clear, the same timeout raises `virt_exc`. If `tw` is also set, `ill_exc` is raised instead.
- R9: A high `spurious_wake` during a stall completes the instruction with `done` in that cycle.
- R10: If a wake condition and the trap timeout fall in the same cycle, `done` is raised and no exception is raised.
- R11: `lowpower_req` is high exactly when `stall_active` is high and neither `done` nor an exception is raised in that cycle. At most one of `done`, `ill_exc` and `virt_exc` is high in any cycle.
- R12: Both counters restart at each new stall, so a second short-timeout stall again lasts STO_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | `insn` is being issued this cycle |
| insn | input | 32 | Instruction word |
| rsv_valid | input | 1 | Reservation set currently held |
| irq_pending | input | IRQ_W | Pending interrupt lines, taken before enable masking |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt | input | 1 | Hart runs in a virtualized (guest) mode |
| tw | input | 1 | Timeout-wait trap enable |
| vtw | input | 1 | Guest timeout-wait trap enable |
| spurious_wake | input | 1 | Implementation-chosen early wake |
| stall_active | output | 1 | Hart is held in the wait |
| lowpower_req | output | 1 | Request to enter the low-power state |
| done | output | 1 | Instruction completes this cycle |
| ill_exc | output | 1 | Illegal-instruction exception request |
| virt_exc | output | 1 | Virtual-instruction exception request |

## Verification
Two pairs of functions can fall in the same cycle: the no-timeout trap limit against a wake, and the short-timeout expiry against a normal wake. The first pair is the hazardous one. The bench parks a trapping no-timeout wait up to its last budget cycle. It then raises an interrupt line in exactly that cycle. The check is that `done` rises while both exception outputs stay low. A companion run repeats the same cycle with no interrupt and expects `ill_exc`. The pair shows that the outcome is decided by the wake condition, not by the counter alone.

// File: rtl/rsv_wait_ctrl.sv
module rsv_wait_ctrl #(
  parameter int IRQ_W    = 16,
  parameter int STO_CYC  = 64,
  parameter int TRAP_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [31:0]      insn,
  input  logic             rsv_valid,
  input  logic [IRQ_W-1:0] irq_pending,
  input  logic [1:0]       priv,
  input  logic             virt,
  input  logic             tw,
  input  logic             vtw,
  input  logic             spurious_wake,
  output logic             stall_active,
  output logic             lowpower_req,
  output logic             done,
  output logic             ill_exc,
  output logic             virt_exc
);
  localparam int STO_W  = $clog2(STO_CYC + 1);
  localparam int TRAP_W = $clog2(TRAP_CYC + 1);
  localparam logic [STO_W-1:0]  STO_LAST  = STO_W'(STO_CYC - 1);
  localparam logic [TRAP_W-1:0] TRAP_LAST = TRAP_W'(TRAP_CYC - 1);
  localparam logic [1:0] PRIV_M = 2'b11;

  logic              sto_mode;
  logic [STO_W-1:0]  sto_cnt;
  logic [TRAP_W-1:0] trap_cnt;

  wire sys_zero = insn[6:0] == 7'h73 && insn[11:7] == 5'd0 &&
                  insn[14:12] == 3'd0 && insn[19:15] == 5'd0;
  wire is_nto = sys_zero && insn[31:20] == 12'h00D;
  wire is_sto = sys_zero && insn[31:20] == 12'h01D;

  wire wake_now    = !rsv_valid || (|irq_pending);
  wire start       = issue_valid && !stall_active && (is_nto || is_sto);
  wire sto_expired = sto_mode && sto_cnt == STO_LAST;
  wire wake        = stall_active && (wake_now || spurious_wake || sto_expired);
  wire trap_hit    = stall_active && !sto_mode && trap_cnt == TRAP_LAST && !wake;
  wire want_ill    = tw && priv != PRIV_M;
  wire want_virt   = virt && vtw && !tw && priv != PRIV_M;

  assign done         = (start && wake_now) || wake;
  assign ill_exc      = trap_hit && want_ill;
  assign virt_exc     = trap_hit && want_virt;
  assign lowpower_req = stall_active && !done && !ill_exc && !virt_exc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_active <= 1'b0;
      sto_mode     <= 1'b0;
      sto_cnt      <= '0;
      trap_cnt     <= '0;
    end else if (start && !wake_now) begin
      stall_active <= 1'b1;
      sto_mode     <= is_sto;
      sto_cnt      <= '0;
      trap_cnt     <= '0;
    end else if (done || ill_exc || virt_exc) begin
      stall_active <= 1'b0;
    end else if (stall_active) begin
      if (sto_mode && sto_cnt != STO_LAST) sto_cnt <= sto_cnt + 1'b1;
      if (!sto_mode && trap_cnt != TRAP_LAST) trap_cnt <= trap_cnt + 1'b1;
    end
  end

  // R11
  lp_only_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowpower_req |-> stall_active && !done);
  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, ill_exc, virt_exc}));
  // R3
  rsv_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_active && !rsv_valid |-> done);
  // R4
  irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_active && (|irq_pending) |-> done && !ill_exc && !virt_exc);
  // R6
  m_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_exc || virt_exc) |-> priv != PRIV_M);
  // R7
  exc_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_exc || virt_exc || done) |=> !stall_active);
endmodule

// File: tb/tb_rsv_wait_ctrl.sv
module tb_rsv_wait_ctrl;
  localparam int IRQ_W = 4, STO_CYC = 8, TRAP_CYC = 16;
  localparam logic [31:0] NTO = 32'h00D00073, STO = 32'h01D00073;

  logic clk = 0, rst_n = 0;
  logic issue_valid = 0, rsv_valid = 1, virt = 0, tw = 0, vtw = 0, spurious_wake = 0;
  logic [31:0] insn = 0;
  logic [IRQ_W-1:0] irq_pending = 0;
  logic [1:0] priv = 2'b11;
  logic stall_active, lowpower_req, done, ill_exc, virt_exc;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  rsv_wait_ctrl #(.IRQ_W(IRQ_W), .STO_CYC(STO_CYC), .TRAP_CYC(TRAP_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .insn(insn),
    .rsv_valid(rsv_valid), .irq_pending(irq_pending), .priv(priv), .virt(virt),
    .tw(tw), .vtw(vtw), .spurious_wake(spurious_wake), .stall_active(stall_active),
    .lowpower_req(lowpower_req), .done(done), .ill_exc(ill_exc), .virt_exc(virt_exc));

  // {insn, rsv_valid, irq_pending, expect: 0 ignored, 1 done at issue, 2 stall}
  localparam int NV = 10;
  localparam logic [38:0] VEC [NV] = '{
    {NTO,          1'b1, 4'b0000, 2'd2},
    {STO,          1'b1, 4'b0000, 2'd2},
    {NTO,          1'b0, 4'b0000, 2'd1},
    {STO,          1'b1, 4'b0100, 2'd1},
    {32'h10500073, 1'b1, 4'b0000, 2'd0},
    {32'h00D000F3, 1'b1, 4'b0000, 2'd0},
    {32'h00D01073, 1'b1, 4'b0000, 2'd0},
    {32'h00D08073, 1'b1, 4'b0000, 2'd0},
    {32'h02D00073, 1'b1, 4'b0000, 2'd0},
    {32'h00D00033, 1'b1, 4'b0000, 2'd0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic issue(logic [31:0] w);
    insn = w; issue_valid = 1; #1;
  endtask

  // step through n quiet stall cycles, each checked for R11 and no outcome
  task automatic quiet(int n, string req);
    for (int i = 0; i < n; i++) begin
      #1;
      chk({req, " quiet stall"}, {stall_active, lowpower_req, done, ill_exc, virt_exc}, 5'b11000);
      cyc();
    end
  endtask

  task automatic release_rsv();
    rsv_valid = 0; #1;
    chk("R3 done on loss", done, 1);
    cyc(); rsv_valid = 1; #1;
    chk("R3 stall cleared", stall_active, 0);
  endtask

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk("R11 reset outputs", {stall_active, lowpower_req, done, ill_exc, virt_exc}, 5'b0);
    cyc(); cyc(); rst_n = 1; cyc();

    for (int v = 0; v < NV; v++) begin
      rsv_valid = VEC[v][6]; irq_pending = VEC[v][5:2];
      issue(VEC[v][38:7]);
      chk(VEC[v][1:0] == 2'd1 ? "R2 done at issue" : "R1 decode done", done, VEC[v][1:0] == 2'd1);
      cyc(); issue_valid = 0; rsv_valid = 1; irq_pending = 0; #1;
      chk(VEC[v][1:0] == 2'd2 ? "R1 stall entered" : "R2 no stall", stall_active, VEC[v][1:0] == 2'd2);
      if (stall_active) release_rsv();
      cyc();
    end

    // R3 after a few cycles
    issue(NTO); cyc(); issue_valid = 0;
    quiet(3, "R3"); release_rsv(); cyc();

    // R4 any single irq line
    issue(NTO); cyc(); issue_valid = 0;
    quiet(2, "R4"); irq_pending = 4'b1000; #1;
    chk("R4 irq wake", {done, ill_exc}, 2'b10);
    cyc(); irq_pending = 0; #1;
    chk("R4 stall cleared", stall_active, 0); cyc();

    // R5 and R12: two short-timeout stalls of full length
    for (int k = 0; k < 2; k++) begin
      priv = 2'b00; tw = 1;
      issue(STO); cyc(); issue_valid = 0;
      quiet(STO_CYC - 1, k == 0 ? "R5" : "R12");
      #1;
      chk(k == 0 ? "R5 timeout done" : "R12 restart done", {done, ill_exc, virt_exc, lowpower_req}, 4'b1000);
      cyc(); #1;
      chk("R5 stall cleared", stall_active, 0); cyc();
    end

    // R7 illegal trap
    priv = 2'b01; tw = 1; virt = 0;
    issue(NTO); cyc(); issue_valid = 0;
    quiet(TRAP_CYC - 1, "R7"); #1;
    chk("R7 ill trap", {done, ill_exc, virt_exc, lowpower_req}, 4'b0100);
    cyc(); #1; chk("R7 stall cleared", stall_active, 0); cyc();

    // R10 wake beats trap in the same cycle
    issue(NTO); cyc(); issue_valid = 0;
    quiet(TRAP_CYC - 1, "R10"); irq_pending = 4'b0001; #1;
    chk("R10 wake wins", {done, ill_exc, virt_exc}, 3'b100);
    cyc(); irq_pending = 0; cyc();

    // R8 virtual trap, then TW precedence
    priv = 2'b00; virt = 1; vtw = 1; tw = 0;
    issue(NTO); cyc(); issue_valid = 0;
    quiet(TRAP_CYC - 1, "R8"); #1;
    chk("R8 virt trap", {done, ill_exc, virt_exc}, 3'b001);
    cyc(); cyc();
    tw = 1;
    issue(NTO); cyc(); issue_valid = 0;
    quiet(TRAP_CYC - 1, "R8"); #1;
    chk("R8 tw precedence", {done, ill_exc, virt_exc}, 3'b010);
    cyc(); cyc();

    // R6 machine mode never traps
    priv = 2'b11; virt = 0; tw = 1; vtw = 1;
    issue(NTO); cyc(); issue_valid = 0;
    quiet(TRAP_CYC + 4, "R6");
    chk("R6 still stalled", stall_active, 1);
    release_rsv(); cyc();

    // R9 spurious wake
    priv = 2'b00; tw = 1;
    issue(NTO); cyc(); issue_valid = 0;
    quiet(2, "R9"); spurious_wake = 1; #1;
    chk("R9 spurious done", {done, ill_exc, lowpower_req}, 3'b100);
    cyc(); spurious_wake = 0; #1;
    chk("R9 stall cleared", stall_active, 0);
    cyc();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule